// File: doc/BRIEF.md
# Serial Debug Command Sequencer

This block sits behind a single-wire debug port. It takes the decoded stream of host bits, one bit per strobe, and assembles them into commands. Each command starts with an 8-bit opcode. Depending on the opcode, the block then takes a 16-bit address, a data byte, a 16-bit word, or nothing further. It then acts on the command. It can issue one read or write on a simple parallel memory bus, update its control byte or its breakpoint word, or return a byte or word to the host. Returned bits go out on a target strobe, one bit per strobe.

Before the first returned bit, the block waits a fixed number of cycles, so the host always has time to turn the line around. Memory access commands take effect only while the CPU is halted. The remaining commands are always accepted. A host that goes quiet in the middle of a command triggers a soft reset, and the partial command is thrown away.

Top module: `dbg_cmd_seq`

## Requirements
- R1: Every command starts with an 8-bit opcode, sent most significant bit first. The opcodes are 8'hE4 status read, 8'hC4 control write, 8'hE2 breakpoint read, 8'hC2 breakpoint write, 8'hE8 memory byte read and 8'hC8 memory byte write. Any other code is dropped without any output, and the next host bit starts a new opcode.
- R2: A status read returns 8 bits, most significant bit first. Bits 7..1 hold the stored control bits. Bit 0 holds the CPU halt input as sampled on the edge that completes the opcode.
- R3: A control write takes 8 data bits. It stores data bits 7..1. Bit 0 of the status byte cannot be written.
- R4: A breakpoint write takes 16 data bits. A breakpoint read returns 16 bits. Bits 15 and 14 always read as zero, and the other bits read back as written.
- R5: A memory read takes a 16-bit address. On the cycle after the edge that takes the last address bit, the block gives a one-cycle mem_req with mem_we low and mem_addr equal to address bits 13..0. Bits 15..14 are ignored. The byte on mem_rdata one cycle after the request is returned as 8 bits.
- R6: A memory write takes a 16-bit address and then 8 data bits. On the cycle after the last data bit, the block gives a one-cycle mem_req with mem_we high, mem_addr equal to address bits 13..0, and mem_wdata equal to the data byte.
- R7: Let edge k be the edge that takes the last host bit of a reading command. The first returned bit is presented with tgt_stb high right after edge k+TURN. The remaining bits follow on consecutive cycles. TURN must lie between 16 and 511.
- R8: The memory read and write commands are halt-only. If cpu_halted is low on the edge that completes the opcode, the command is still taken in full, but no mem_req is issued and a memory read returns 8'h00.
- R9: While a command is partly received, an abort happens if no host strobe comes on any of the 512 edges after the last accepted bit. The partial command is dropped. A strobe that lands on the 512th edge is still accepted.
- R10: Host strobes that arrive while a reply is pending or being sent are ignored.
- R11: After reset, tgt_stb and mem_req are low, the control bits are zero and the breakpoint is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous active-high reset |
| host_stb | input | 1 | Host bit valid strobe |
| host_bit | input | 1 | Host bit value |
| cpu_halted | input | 1 | High while the CPU is in background (halted) mode |
| tgt_stb | output | 1 | Returned bit valid |
| tgt_bit | output | 1 | Returned bit value |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |

## Verification
The idle watchdog and the arrival of a host bit can fall on the same edge: the 512th edge after the last accepted bit of a partial command. The bench stops a memory write after five address bits. In one case it places the next bit exactly on that 512th edge and expects the write to finish normally on the bus. In the other case it places the bit one edge later and expects that bit to begin a fresh status read, with no bus traffic at all. The reference model in the bench predicts the exact cycle of every returned bit and every bus request, and a bit or request that appears on any other cycle is reported as a failure.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [1:0] {S_CMD, S_ADDR, S_DATA, S_REPLY} seq_state_t;

  typedef enum logic [2:0] {
    K_NONE, K_STAT_RD, K_CTRL_WR, K_BKPT_RD, K_BKPT_WR, K_MEM_RD, K_MEM_WR
  } cmd_kind_t;

  localparam logic [7:0] OP_STAT_RD = 8'hE4;
  localparam logic [7:0] OP_CTRL_WR = 8'hC4;
  localparam logic [7:0] OP_BKPT_RD = 8'hE2;
  localparam logic [7:0] OP_BKPT_WR = 8'hC2;
  localparam logic [7:0] OP_MEM_RD  = 8'hE8;
  localparam logic [7:0] OP_MEM_WR  = 8'hC8;

  function automatic cmd_kind_t decode_op(input logic [7:0] op);
    case (op)
      OP_STAT_RD: return K_STAT_RD;
      OP_CTRL_WR: return K_CTRL_WR;
      OP_BKPT_RD: return K_BKPT_RD;
      OP_BKPT_WR: return K_BKPT_WR;
      OP_MEM_RD:  return K_MEM_RD;
      OP_MEM_WR:  return K_MEM_WR;
      default:    return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dbg_seq_rx.sv
module dbg_seq_rx #(
  parameter int IDLE_LIM = 512,
  parameter int FW       = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          mid,
  input  logic          bit_stb,
  input  logic          bit_in,
  input  logic [4:0]    len,
  output logic          done,
  output logic [FW-1:0] word,
  output logic          abort
);
  localparam int IW = $clog2(IDLE_LIM + 1);

  logic [4:0]    cnt;
  logic [FW-1:0] sh;
  logic [IW-1:0] idle;
  logic          take, active;

  assign take   = en && bit_stb;
  assign word   = {sh[FW-2:0], bit_in};
  assign done   = take && (cnt == len - 5'd1);
  assign active = en && (mid || cnt != 5'd0);
  assign abort  = active && !bit_stb && (idle == IW'(IDLE_LIM - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sh   <= '0;
      idle <= '0;
    end else begin
      if (!en || abort)   cnt <= '0;
      else if (take)      cnt <= done ? 5'd0 : cnt + 5'd1;
      if (take)           sh  <= word;
      if (take || !active || abort) idle <= '0;
      else                idle <= idle + 1'b1;
    end
  end

  // R9
  abort_clr_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (cnt == 5'd0));

  // R1
  cnt_rng_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < 5'd16);

endmodule

// File: rtl/dbg_seq_tx.sv
module dbg_seq_tx #(
  parameter int TURN = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        load,
  input  logic        wide,
  input  logic [15:0] data,
  output logic        tx_stb,
  output logic        tx_bit,
  output logic        busy
);
  localparam int CW = $clog2(TURN + 1);

  logic [CW-1:0] wcnt;
  logic [4:0]    sent;
  logic          wide_q, shifting;
  logic [15:0]   sh;

  function automatic logic [15:0] align(input logic [15:0] d, input logic w);
    return w ? d : {d[7:0], 8'h00};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0; sent <= '0; wide_q <= 1'b0; shifting <= 1'b0;
      sh <= '0; tx_stb <= 1'b0; tx_bit <= 1'b0; busy <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      shifting <= 1'b0;
      wcnt     <= CW'(1);
      wide_q   <= wide;
      sh       <= align(data, wide);
      tx_stb   <= 1'b0;
    end else if (busy) begin
      if (!shifting) begin
        if (wcnt == CW'(TURN)) begin
          shifting <= 1'b1;
          tx_stb   <= 1'b1;
          tx_bit   <= sh[15];
          sh       <= {sh[14:0], 1'b0};
          sent     <= 5'd1;
        end else begin
          wcnt <= wcnt + 1'b1;
          if (load) sh <= align(data, wide_q);
        end
      end else if (sent == (wide_q ? 5'd16 : 5'd8)) begin
        tx_stb   <= 1'b0;
        tx_bit   <= 1'b0;
        busy     <= 1'b0;
        shifting <= 1'b0;
      end else begin
        tx_bit <= sh[15];
        sh     <= {sh[14:0], 1'b0};
        sent   <= sent + 5'd1;
      end
    end
  end

  // R7
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !tx_stb);

  // R7
  end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_stb) |-> !busy);

endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_seq_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int TURN     = 16,
  parameter int IDLE_LIM = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_stb,
  input  logic              host_bit,
  input  logic              cpu_halted,
  output logic              tgt_stb,
  output logic              tgt_bit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int FW = 16;
  localparam int HI = FW - ADDR_W;

  seq_state_t        state;
  cmd_kind_t         kind, op_kind;
  logic              ok_q, rd_cap;
  logic [7:1]        ctrl_q;
  logic [ADDR_W-1:0] bkpt_q;

  logic              rx_en, rx_mid, rx_done, rx_abort;
  logic [4:0]        rx_len;
  logic [FW-1:0]     word;
  logic [HI-1:0]     unused_hi;

  logic              tx_start, tx_load, tx_wide, tx_busy;
  logic [15:0]       tx_data;

  assign unused_hi = word[FW-1:ADDR_W];
  assign op_kind   = decode_op(word[7:0]);
  assign rx_en     = (state != S_REPLY);
  assign rx_mid    = (state == S_ADDR) || (state == S_DATA);

  always_comb begin
    case (state)
      S_ADDR:  rx_len = 5'd16;
      S_DATA:  rx_len = (kind == K_BKPT_WR) ? 5'd16 : 5'd8;
      default: rx_len = 5'd8;
    endcase
  end

  dbg_seq_rx #(.IDLE_LIM(IDLE_LIM), .FW(FW)) rx_i (
    .clk(clk), .rst(rst), .en(rx_en), .mid(rx_mid),
    .bit_stb(host_stb), .bit_in(host_bit), .len(rx_len),
    .done(rx_done), .word(word), .abort(rx_abort)
  );

  // reply launch: decided on the edge that completes the relevant field
  always_comb begin
    tx_start = 1'b0;
    tx_wide  = 1'b0;
    tx_data  = 16'h0000;
    if (rx_done && state == S_CMD && op_kind == K_STAT_RD) begin
      tx_start = 1'b1;
      tx_data  = {8'h00, ctrl_q, cpu_halted};
    end else if (rx_done && state == S_CMD && op_kind == K_BKPT_RD) begin
      tx_start = 1'b1;
      tx_wide  = 1'b1;
      tx_data  = 16'(bkpt_q);
    end else if (rx_done && state == S_ADDR && kind == K_MEM_RD) begin
      tx_start = 1'b1;
    end else if (rd_cap) begin
      tx_data  = {8'h00, mem_rdata};
    end
  end
  assign tx_load = rd_cap;

  dbg_seq_tx #(.TURN(TURN)) tx_i (
    .clk(clk), .rst(rst), .start(tx_start), .load(tx_load),
    .wide(tx_wide), .data(tx_data),
    .tx_stb(tgt_stb), .tx_bit(tgt_bit), .busy(tx_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_CMD;
      kind      <= K_NONE;
      ok_q      <= 1'b0;
      rd_cap    <= 1'b0;
      ctrl_q    <= '0;
      bkpt_q    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      rd_cap  <= mem_req && !mem_we;
      if (rx_abort) begin
        state <= S_CMD;
      end else begin
        case (state)
          S_CMD: if (rx_done) begin
            kind <= op_kind;
            ok_q <= cpu_halted;
            case (op_kind)
              K_STAT_RD, K_BKPT_RD: state <= S_REPLY;
              K_CTRL_WR, K_BKPT_WR: state <= S_DATA;
              K_MEM_RD,  K_MEM_WR:  state <= S_ADDR;
              default:              state <= S_CMD;
            endcase
          end
          S_ADDR: if (rx_done) begin
            mem_addr <= word[ADDR_W-1:0];
            if (kind == K_MEM_RD) begin
              mem_req <= ok_q;
              mem_we  <= 1'b0;
              state   <= S_REPLY;
            end else begin
              state   <= S_DATA;
            end
          end
          S_DATA: if (rx_done) begin
            case (kind)
              K_CTRL_WR: ctrl_q <= word[7:1];
              K_BKPT_WR: bkpt_q <= word[ADDR_W-1:0];
              K_MEM_WR: begin
                mem_req   <= ok_q;
                mem_we    <= 1'b1;
                mem_wdata <= word[7:0];
              end
              default: ;
            endcase
            state <= S_CMD;
          end
          S_REPLY: if (!tx_busy) state <= S_CMD;
          default: state <= S_CMD;
        endcase
      end
    end
  end

  // R5
  mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R8
  halt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ok_q);

  // R10
  reply_only_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_stb |-> (state == S_REPLY));

endmodule

// File: tb/dbg_cmd_seq_tb.sv
module dbg_cmd_seq_tb_top;
  localparam int TURN = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic host_stb = 1'b0, host_bit = 1'b0, cpu_halted = 1'b1;
  logic tgt_stb, tgt_bit, mem_req, mem_we;
  logic [13:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  dbg_cmd_seq #(.ADDR_W(14), .TURN(TURN), .IDLE_LIM(512)) dut_i (
    .clk(clk), .rst(rst), .host_stb(host_stb), .host_bit(host_bit),
    .cpu_halted(cpu_halted), .tgt_stb(tgt_stb), .tgt_bit(tgt_bit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  typedef struct { int at; logic b; string req; } txe_t;
  typedef struct { int at; logic we; logic [13:0] a; logic [7:0] d; string req; } mev_t;
  txe_t txq[$];
  mev_t mq[$];

  int cyc = 0, checks = 0, fails = 0;
  bit finished = 1'b0;
  string cur = "R11";
  logic [7:0] mem [16384];
  logic [7:1] ctrl_m = '0;

  initial for (int i = 0; i < 16384; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic fail(string r, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", r, what, act, exp, cyc);
  endtask

  // reference comparison on every clock
  always @(negedge clk) if (!rst && !finished) begin
    checks++;
    if (txq.size() > 0 && txq[0].at == cyc) begin
      if (!(tgt_stb === 1'b1 && tgt_bit === txq[0].b))
        fail(txq[0].req, "reply bit", {tgt_stb, tgt_bit}, {1'b1, txq[0].b});
      void'(txq.pop_front());
    end else if (tgt_stb !== 1'b0) fail(cur, "unexpected tgt_stb", tgt_stb, 0);
    checks++;
    if (mq.size() > 0 && mq[0].at == cyc) begin
      if (!(mem_req === 1'b1 && mem_we === mq[0].we && mem_addr === mq[0].a &&
            (!mq[0].we || mem_wdata === mq[0].d)))
        fail(mq[0].req, "bus req", {mem_req, mem_we, mem_addr, mem_wdata},
             {1'b1, mq[0].we, mq[0].a, mq[0].d});
      void'(mq.pop_front());
    end else if (mem_req !== 1'b0) fail(cur, "unexpected mem_req", mem_req, 0);
  end

  task automatic send(logic [15:0] v, int n, output int k);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); host_stb = 1'b1; host_bit = v[i]; k = cyc + 1;
    end
    @(negedge clk); host_stb = 1'b0; host_bit = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_tx(int k, logic [15:0] v, int n, string r);
    for (int j = 0; j < n; j++) txq.push_back('{k + TURN + j, v[n-1-j], r});
  endtask

  task automatic rd_status(string r);
    int k;
    cur = r;
    send(16'hE4, 8, k);
    exp_tx(k, {8'h00, ctrl_m, cpu_halted}, 8, r);
    idle(TURN + 12);
  endtask

  task automatic wr_ctrl(logic [7:0] d, string r);
    int k;
    cur = r;
    send(16'hC4, 8, k); send(16'(d), 8, k);
    ctrl_m = d[7:1];
    idle(3);
  endtask

  task automatic wr_bkpt(logic [15:0] d, string r);
    int k;
    cur = r;
    send(16'hC2, 8, k); send(d, 16, k);
    idle(3);
  endtask

  task automatic rd_bkpt(logic [15:0] e, string r);
    int k;
    cur = r;
    send(16'hE2, 8, k);
    exp_tx(k, e, 16, r);
    idle(TURN + 20);
  endtask

  task automatic mem_rd(logic [15:0] a, string r);
    int k;
    logic ok;
    cur = r;
    ok = cpu_halted;
    send(16'hE8, 8, k); send(a, 16, k);
    if (ok) mq.push_back('{k, 1'b0, a[13:0], 8'h00, r});
    exp_tx(k, ok ? {8'h00, mem[a[13:0]]} : 16'h0000, 8, r);
    idle(TURN + 12);
  endtask

  task automatic mem_wr(logic [15:0] a, logic [7:0] d, string r);
    int k;
    cur = r;
    send(16'hC8, 8, k); send(a, 16, k); send(16'(d), 8, k);
    if (cpu_halted) mq.push_back('{k, 1'b1, a[13:0], d, r});
    idle(3);
  endtask

  initial begin
    int k;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (tgt_stb !== 1'b0 || mem_req !== 1'b0) fail("R11", "outputs after reset", {tgt_stb, mem_req}, 0);
    rd_status("R11");
    rd_bkpt(16'h0000, "R11");

    wr_ctrl(8'hA7, "R3");
    rd_status("R2");
    cpu_halted = 1'b0;
    rd_status("R2");
    wr_ctrl(8'h58, "R3");
    rd_status("R3");
    cpu_halted = 1'b1;

    wr_bkpt(16'hFFFF, "R4");
    rd_bkpt(16'h3FFF, "R4");
    wr_bkpt(16'h5A5A, "R4");
    rd_bkpt(16'h1A5A, "R4");

    mem_rd(16'hC012, "R5");
    mem_wr(16'h8123, 8'h3C, "R6");
    mem_rd(16'h0123, "R6");
    mem_rd(16'h3FFF, "R7");

    cpu_halted = 1'b0;
    mem_wr(16'h0040, 8'h99, "R8");
    mem_rd(16'h0040, "R8");
    cpu_halted = 1'b1;
    mem_rd(16'h0040, "R8");
    // halt sampled with the opcode only
    cur = "R8";
    send(16'hE8, 8, k);
    cpu_halted = 1'b0;
    send(16'h0055, 16, k);
    mq.push_back('{k, 1'b0, 14'h0055, 8'h00, "R8"});
    exp_tx(k, {8'h00, mem[14'h0055]}, 8, "R8");
    idle(TURN + 12);
    cpu_halted = 1'b1;

    cur = "R1";
    send(16'h37, 8, k);
    idle(TURN + 8);
    rd_status("R1");

    // R10: strobes during the turnaround are ignored
    cur = "R10";
    send(16'hE4, 8, k);
    exp_tx(k, {8'h00, ctrl_m, cpu_halted}, 8, "R10");
    send(16'h7, 3, k);
    idle(TURN + 10);
    rd_status("R10");

    // R9: bit on the 512th idle edge is still accepted
    cur = "R9";
    send(16'hC8, 8, k);
    send(16'h0ABC >> 11, 5, k);
    idle(510);
    send(16'h0ABC >> 10, 1, k);
    send(16'h0ABC, 10, k);
    send(16'h00E1, 8, k);
    mq.push_back('{k, 1'b1, 14'h0ABC, 8'hE1, "R9"});
    idle(3);
    mem_rd(16'h0ABC, "R9");

    // R9: one edge later the partial command is dropped
    cur = "R9";
    send(16'hC8, 8, k);
    send(16'h1234 >> 11, 5, k);
    idle(511);
    rd_status("R9");
    mem_rd(16'h1234, "R9");

    idle(4);
    checks++;
    if (txq.size() != 0 || mq.size() != 0) fail("R7", "pending expectations", txq.size() + mq.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule